// File: doc/BRIEF.md
# Shadow Memory Attribute Controller

This block decides how CPU memory accesses are routed in the legacy upper-memory window that spans 0xC0000 to 0xFFFFF. Software programs seven 8-bit attribute bytes through a 32-bit configuration port that has byte enables. Each 4-bit attribute field governs one segment of the window. Its read-enable bit chooses whether a read is served from shadow RAM or from ROM. Its write-enable bit chooses whether a write lands in shadow RAM or is thrown away.

The memory side is a combinational decode. On every valid access the block drives a RAM select, a ROM select and per-byte RAM write strobes. These outputs follow the address, the direction and the byte mask in the same cycle, so a shadow write takes effect in the cycle its strobe is driven. The storage arrays sit outside the block. Accesses outside the window get no select at all.

The configuration port has no back-pressure. A request with `cfg_valid` high is accepted in that cycle. A write commits at the clock edge, and the access in the following cycle already sees the new attributes. A read returns its word one cycle later, flagged by `cfg_rvalid`. The memory side is a plain decode with no handshake.

Top module: `shadow_attr_ctl`

## Requirements
- R1: After reset every attribute byte (offsets 0x59..0x5F) is 0x00, and so is byte 0x58. Offsets 0x60..0x65 read 0x02 and offsets 0x66..0x67 read 0x00. As a result, every in-window read selects ROM and every in-window write is dropped.
- R2: A configuration write with `cfg_valid`=1 and `cfg_we`=1 updates the byte at offset `{cfg_addr[7:2],2'bk}` from `cfg_wdata[8k+7:8k]` for each lane k whose `cfg_be[k]` is 1. Bytes of lanes whose enable is 0 keep their value.
- R3: A configuration read (`cfg_valid`=1, `cfg_we`=0) raises `cfg_rvalid` in the next cycle. It returns in `cfg_rdata` the four bytes of that dword, lane k in bits 8k+7:8k, whatever `cfg_be` is. Reserved bits read back as written. Offsets outside 0x58..0x67 read 0 and ignore writes.
- R4: Segment map. The high nibble of offset 0x59 governs 0xF0000..0xFFFFF. Offsets 0x5A..0x5F each govern two consecutive 16 KB segments counted upward from 0xC0000: the low nibble governs the lower segment and the high nibble the upper one.
- R5: Within a nibble, bit 0 is read enable. For an in-window read, the block asserts `ram_sel` if bit 0 is 1 and `rom_sel` if it is 0.
- R6: Within a nibble, bit 1 is write enable. For an in-window write with bit 1 set, the block asserts `ram_sel` and sets `ram_wstrb` equal to `mem_be`. With bit 1 clear, both selects and all strobes stay 0. `rom_sel` is never asserted for a write.
- R7: Nibble bit 2 (cache) and bit 3 (reserved), and the whole low nibble of offset 0x59, have no effect on routing.
- R8: An access whose address lies outside 0xC0000..0xFFFFF asserts no select and no strobe.
- R9: The memory outputs are combinational in the same cycle as the access. An attribute write that commits at a clock edge governs the access in the next cycle and not the one in its own cycle.
- R10: While `mem_valid` is 0, `ram_sel`, `rom_sel` and `ram_wstrb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration request; always accepted |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Configuration byte offset (bits 1:0 ignored) |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cfg_rdata | output | 32 | Read data, held until the next read |
| mem_valid | input | 1 | CPU memory access present |
| mem_we | input | 1 | 1 = write access, 0 = read access |
| mem_addr | input | ADDR_W | CPU byte address |
| mem_be | input | 4 | CPU byte mask |
| ram_sel | output | 1 | Access goes to shadow RAM |
| rom_sel | output | 1 | Read goes to ROM |
| ram_wstrb | output | 4 | Per-byte shadow RAM write strobes |

## Verification
The attribute bytes are first loaded with a mix of patterns: read only, write only, both enabled, neither enabled, and cache or reserved bits alone. Reads and writes are then issued at the first and last dword of each segment, so that a wrong nibble choice or an off-by-one register index shows up as a swapped RAM/ROM select. Partial byte masks on writes separate the strobe path from a plain all-ones enable. Addresses just below the window, just above it and aliased in the upper address bits confirm the window compare. Partial-lane configuration writes and read-back of reserved bits expose lane mapping errors.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
  // configuration space geometry
  localparam int          CFG_AW      = 8;
  localparam logic [7:0]  WIN_BASE    = 8'h58;   // dword aligned start of stored bytes
  localparam int          WIN_DWORDS  = 4;
  localparam int          WIN_BYTES   = WIN_DWORDS * 4;
  localparam logic [7:0]  ATTR_BASE   = 8'h59;
  localparam int          N_ATTR      = 7;
  localparam int          ATTR_OFS    = int'(ATTR_BASE) - int'(WIN_BASE);
  localparam logic [7:0]  DEF2_LO     = 8'h60;
  localparam logic [7:0]  DEF2_HI     = 8'h65;

  // memory window geometry: 256 KB window at 0xC0000, 16 KB segments
  localparam int          WIN_LSB     = 18;
  localparam int          SEG_LSB     = 14;
  localparam int          WIN_TAG     = 3;

  typedef struct packed {
    logic rsvd;
    logic cache;
    logic wr_en;
    logic rd_en;
  } attr_nib_t;

  function automatic logic [7:0] reset_byte(input logic [7:0] off);
    return (off >= DEF2_LO && off <= DEF2_HI) ? 8'h02 : 8'h00;
  endfunction
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_valid,
  input  logic                   cfg_we,
  input  logic [CFG_AW-1:0]      cfg_addr,
  input  logic [3:0]             cfg_be,
  input  logic [31:0]            cfg_wdata,
  output logic                   cfg_rvalid,
  output logic [31:0]            cfg_rdata,
  output logic [N_ATTR*8-1:0]    attr_flat
);
  logic [7:0]  regs [WIN_BYTES];
  logic [31:0] rd_word;
  logic [1:0]  unused_addr_lo;

  assign unused_addr_lo = cfg_addr[1:0];

  // R1 reset defaults, R2 per-lane writes
  always_ff @(posedge clk) begin
    for (int b = 0; b < WIN_BYTES; b++) begin
      if (!rst_n) begin
        regs[b] <= reset_byte(WIN_BASE + 8'(b));
      end else if (cfg_valid && cfg_we) begin
        for (int l = 0; l < 4; l++) begin
          if (cfg_be[l] && ({cfg_addr[CFG_AW-1:2], 2'(l)} == WIN_BASE + 8'(b)))
            regs[b] <= cfg_wdata[8*l +: 8];
        end
      end
    end
  end

  // R3 read path: bytes outside the stored window read zero
  always_comb begin
    rd_word = '0;
    for (int l = 0; l < 4; l++) begin
      for (int b = 0; b < WIN_BYTES; b++) begin
        if ({cfg_addr[CFG_AW-1:2], 2'(l)} == WIN_BASE + 8'(b))
          rd_word[8*l +: 8] = regs[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_valid && !cfg_we;
      if (cfg_valid && !cfg_we)
        cfg_rdata <= rd_word;
    end
  end

  generate
    for (genvar a = 0; a < N_ATTR; a++) begin : g_attr
      assign attr_flat[8*a +: 8] = regs[ATTR_OFS + a];
    end
  endgenerate
endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [N_ATTR*8-1:0]    attr_flat,
  output logic                   hit,
  output logic                   rd_en,
  output logic                   wr_en
);
  localparam int TOP_W = ADDR_W - WIN_LSB;
  localparam int SEG_W = WIN_LSB - SEG_LSB;

  logic [SEG_W-1:0] seg;
  logic [2:0]       ridx;
  logic [7:0]       rbyte;
  attr_nib_t        nib;
  logic [1:0]       unused_nib_bits;
  logic [SEG_LSB-1:0] unused_addr_lo;

  assign unused_addr_lo  = addr[SEG_LSB-1:0];
  assign unused_nib_bits = {nib.cache, nib.rsvd};   // R7: no routing effect

  // R4 segment map, R8 window compare
  always_comb begin
    hit  = (addr[ADDR_W-1:WIN_LSB] == TOP_W'(WIN_TAG));
    seg  = addr[WIN_LSB-1:SEG_LSB];
    if (seg[SEG_W-1 -: 2] == 2'b11) begin
      ridx  = 3'd0;                       // 64 KB top segment, high nibble
      rbyte = attr_flat[7:0];
      nib   = attr_nib_t'(rbyte[7:4]);
    end else begin
      ridx  = seg[SEG_W-1:1] + 3'd1;
      rbyte = attr_flat[8*ridx +: 8];
      nib   = seg[0] ? attr_nib_t'(rbyte[7:4]) : attr_nib_t'(rbyte[3:0]);
    end
    rd_en = nib.rd_en;
    wr_en = nib.wr_en;
  end
endmodule

// File: rtl/shadow_route.sv
module shadow_route (
  input  logic       mem_valid,
  input  logic       mem_we,
  input  logic [3:0] mem_be,
  input  logic       hit,
  input  logic       rd_en,
  input  logic       wr_en,
  output logic       ram_sel,
  output logic       rom_sel,
  output logic [3:0] ram_wstrb
);
  // R5 read routing, R6 write routing, R8/R10 quiet otherwise
  always_comb begin
    ram_sel   = 1'b0;
    rom_sel   = 1'b0;
    ram_wstrb = 4'h0;
    if (mem_valid && hit) begin
      if (mem_we) begin
        if (wr_en) begin
          ram_sel   = 1'b1;
          ram_wstrb = mem_be;
        end
      end else if (rd_en) begin
        ram_sel = 1'b1;
      end else begin
        rom_sel = 1'b1;
      end
    end
  end
endmodule

// File: rtl/shadow_attr_ctl.sv
module shadow_attr_ctl
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic              cfg_rvalid,
  output logic [31:0]       cfg_rdata,
  input  logic              mem_valid,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [3:0]        mem_be,
  output logic              ram_sel,
  output logic              rom_sel,
  output logic [3:0]        ram_wstrb
);
  logic [N_ATTR*8-1:0] attr_flat;
  logic                seg_hit;
  logic                seg_rd_en;
  logic                seg_wr_en;

  shadow_cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rdata  (cfg_rdata),
    .attr_flat  (attr_flat)
  );

  shadow_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (mem_addr),
    .attr_flat (attr_flat),
    .hit       (seg_hit),
    .rd_en     (seg_rd_en),
    .wr_en     (seg_wr_en)
  );

  shadow_route u_route (
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .hit       (seg_hit),
    .rd_en     (seg_rd_en),
    .wr_en     (seg_wr_en),
    .ram_sel   (ram_sel),
    .rom_sel   (rom_sel),
    .ram_wstrb (ram_wstrb)
  );
endmodule

// File: rtl/shadow_attr_chk.sv
module shadow_attr_chk
  import shadow_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic              cfg_we,
  input logic              cfg_rvalid,
  input logic              mem_valid,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              ram_sel,
  input logic              rom_sel,
  input logic [3:0]        ram_wstrb
);
  logic in_win;
  logic [WIN_LSB-1:0] unused_lo;
  assign in_win    = (mem_addr[ADDR_W-1:WIN_LSB] == (ADDR_W-WIN_LSB)'(WIN_TAG));
  assign unused_lo = mem_addr[WIN_LSB-1:0];

  a_r8_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !in_win) |-> (!ram_sel && !rom_sel && ram_wstrb == 4'h0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> (!ram_sel && !rom_sel && ram_wstrb == 4'h0));

  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, rom_sel}));

  a_r6_strobe_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wstrb != 4'h0) |-> (mem_we && ram_sel && (ram_wstrb & ~mem_be) == 4'h0));

  a_r6_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> !mem_we);

  a_r3_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_we) |=> cfg_rvalid);

  a_r3_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid |-> $past(cfg_valid && !cfg_we));
endmodule

bind shadow_attr_ctl shadow_attr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_valid  (cfg_valid),
  .cfg_we     (cfg_we),
  .cfg_rvalid (cfg_rvalid),
  .mem_valid  (mem_valid),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .ram_sel    (ram_sel),
  .rom_sel    (rom_sel),
  .ram_wstrb  (ram_wstrb)
);

// File: tb/shadow_attr_ctl_bench.sv
module shadow_attr_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  // {addr, we, be, exp_ram, exp_rom, exp_strb}
  localparam logic [42:0] VEC [NVEC] = '{
    {32'h000C0010, 1'b0, 4'hF, 1'b1, 1'b0, 4'h0},
    {32'h000C0010, 1'b1, 4'hF, 1'b0, 1'b0, 4'h0},
    {32'h000C4000, 1'b0, 4'hF, 1'b0, 1'b1, 4'h0},
    {32'h000C7FFC, 1'b1, 4'h5, 1'b1, 1'b0, 4'h5},
    {32'h000C8000, 1'b0, 4'hF, 1'b0, 1'b1, 4'h0},
    {32'h000CBFF0, 1'b1, 4'hF, 1'b0, 1'b0, 4'h0},
    {32'h000CC000, 1'b0, 4'hF, 1'b0, 1'b1, 4'h0},
    {32'h000D0000, 1'b1, 4'h3, 1'b1, 1'b0, 4'h3},
    {32'h000D3FFC, 1'b0, 4'hF, 1'b1, 1'b0, 4'h0},
    {32'h000D4000, 1'b0, 4'hF, 1'b0, 1'b1, 4'h0},
    {32'h000DC100, 1'b0, 4'hF, 1'b1, 1'b0, 4'h0},
    {32'h000DC100, 1'b1, 4'hF, 1'b0, 1'b0, 4'h0},
    {32'h000E0000, 1'b0, 4'hF, 1'b0, 1'b1, 4'h0},
    {32'h000E0000, 1'b1, 4'hF, 1'b1, 1'b0, 4'hF},
    {32'h000E4000, 1'b0, 4'hF, 1'b1, 1'b0, 4'h0},
    {32'h000E8000, 1'b0, 4'hF, 1'b1, 1'b0, 4'h0},
    {32'h000EC000, 1'b0, 4'hF, 1'b0, 1'b1, 4'h0},
    {32'h000F0000, 1'b0, 4'hF, 1'b1, 1'b0, 4'h0},
    {32'h000FFFFC, 1'b1, 4'h8, 1'b1, 1'b0, 4'h8},
    {32'h000BFFFC, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0},
    {32'h00100000, 1'b1, 4'hF, 1'b0, 1'b0, 4'h0},
    {32'h100C0000, 1'b0, 4'hF, 1'b0, 1'b0, 4'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0, cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rvalid;
  logic [31:0] cfg_rdata;
  logic        mem_valid = 1'b0, mem_we = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [3:0]  mem_be = '0;
  logic        ram_sel, rom_sel;
  logic [3:0]  ram_wstrb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_attr_ctl u_shadow_attr_ctl (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .ram_wstrb(ram_wstrb)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [7:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_we = 1'b0; cfg_addr = a; cfg_be = 4'h0;
    @(negedge clk);
    cfg_valid = 1'b0;
    #1;
    chk(tag, "cfg_rvalid", 32'(cfg_rvalid), 32'd1);
    chk(tag, $sformatf("cfg_rdata @%h", a), cfg_rdata, exp);
  endtask

  // drives an access at a negedge and compares {ram_sel, rom_sel, ram_wstrb}
  task automatic mem_access(input logic [31:0] a, input logic we, input logic [3:0] be,
                            input logic [5:0] exp, input string tag);
    @(negedge clk);
    mem_valid = 1'b1; mem_addr = a; mem_we = we; mem_be = be;
    #1;
    chk(tag, $sformatf("route @%h we=%0b", a, we), 32'({ram_sel, rom_sel, ram_wstrb}), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    cfg_read(8'h58, "R1", 32'h0000_0000);
    cfg_read(8'h5C, "R1", 32'h0000_0000);
    cfg_read(8'h60, "R1", 32'h0202_0202);
    cfg_read(8'h64, "R1", 32'h0000_0202);
    mem_access(32'h000F0000, 1'b0, 4'hF, 6'b01_0000, "R1");
    mem_access(32'h000D0000, 1'b1, 4'hF, 6'b00_0000, "R1");

    // R10 idle: valid low with an in-window address
    @(negedge clk);
    mem_valid = 1'b0; mem_addr = 32'h000C0000; mem_we = 1'b1; mem_be = 4'hF;
    #1 chk("R10", "idle outputs", 32'({ram_sel, rom_sel, ram_wstrb}), 32'd0);

    // R2 programming: lane 0 disabled keeps byte 0x58 at zero
    cfg_write(8'h58, 4'b1110, 32'h4C21_30AA);
    cfg_write(8'h5C, 4'b1111, 32'h0132_1003);
    cfg_read(8'h58, "R2", 32'h4C21_3000);
    cfg_read(8'h5C, "R2", 32'h0132_1003);   // R3 reserved bits kept (0x4C above too)

    // R4 R5 R6 R7 R8 table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] a;
      string tag;
      a = VEC[i][42:11];
      if (a < 32'h000C0000 || a > 32'h000FFFFF) tag = "R8";
      else if (VEC[i][10]) tag = "R4 R6";
      else tag = "R4 R5";
      mem_access(a, VEC[i][10], VEC[i][9:6], VEC[i][5:0], tag);
    end
    @(negedge clk) mem_valid = 1'b0;

    // R7 low nibble of 0x59 and cache bit do not route
    cfg_write(8'h58, 4'b0010, 32'h0000_0F00);
    mem_access(32'h000F8000, 1'b0, 4'hF, 6'b01_0000, "R7");
    mem_access(32'h000F8000, 1'b1, 4'hF, 6'b00_0000, "R7");

    // R9 same-cycle write does not affect that cycle's access
    @(negedge clk);
    mem_valid = 1'b1; mem_we = 1'b0; mem_addr = 32'h000F4000; mem_be = 4'hF;
    cfg_valid = 1'b1; cfg_we = 1'b1; cfg_addr = 8'h58; cfg_be = 4'b0010; cfg_wdata = 32'h0000_3000;
    #1 chk("R9", "old attr in write cycle", 32'({ram_sel, rom_sel}), 32'b01);
    @(negedge clk);
    cfg_valid = 1'b0; cfg_we = 1'b0; cfg_be = '0;
    #1 chk("R9", "new attr next cycle", 32'({ram_sel, rom_sel}), 32'b10);
    @(negedge clk) mem_valid = 1'b0;

    // R3 outside stored window: write ignored, reads zero
    cfg_write(8'h80, 4'hF, 32'hDEAD_BEEF);
    cfg_read(8'h80, "R3", 32'h0000_0000);
    cfg_read(8'h64, "R3", 32'h0000_0202);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule